// File: doc/BRIEF.md
# Oscillator Frequency Count Monitor

This block watches a free-running ring oscillator used as an entropy source and decides whether its frequency is plausible. In run mode it measures back-to-back windows, each a programmable number of system clocks long. Within a window it counts the oscillator's rising edges after bringing the oscillator into the system clock domain. When a window closes, the count is compared against a programmable lower and upper bound. A count outside those bounds raises a frequency error. The error stays set, and while it is set the generator behind the monitor must not be treated as seeded.

Software sets the block up through a small word-addressed register port. It first sets the program bit. It then writes the window length and the two bounds, and clears the program bit to start measuring. The intended setup puts the lower bound at a quarter of the window length and the upper bound at eight times the window length. The reset values follow that rule.

Top module: `osc_freq_monitor`

## Requirements
- R1: After reset the block is in program mode. The window length is DEF_LEN, the lower bound is DEF_LEN/4 and the upper bound is 8*DEF_LEN, clipped to 2^CNT_W-1. sample_done, freq_err and seeded are all 0.
- R2: The register port uses word addresses. Address 0 holds the program bit at bit 0. Address 1 holds the window length at bits 31:16, and its other bits read 0. Address 2 holds the lower bound and address 3 the upper bound, both right-aligned. A write takes effect at the clock edge where reg_wr is high. reg_rdata follows reg_addr with no delay.
- R3: Writes to addresses 1, 2 and 3 are ignored while the program bit is 0. Writes to address 0 are always accepted.
- R4: While the program bit is 1, no window runs: sample_done stays 0 and freq_err and seeded are held at 0.
- R5: In run mode, windows of L system clocks follow each other with no gap, where L is the window length. A length of 0 behaves as 1. sample_done is high for one cycle after the last clock of each window.
- R6: The count of a window is the number of rising edges of osc_in that reach the system domain through a two-flop synchronizer during that window. A count above the upper bound sets freq_err.
- R7: A count below the lower bound also sets freq_err. A count equal to either bound does not.
- R8: The edge count saturates at 2^CNT_W-1 instead of wrapping.
- R9: Once set, freq_err stays 1 in run mode, even if later windows are within bounds, until the program bit is set.
- R10: seeded becomes 1 at the end of an in-bounds window while freq_err is 0. seeded is 0 whenever freq_err is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_in | input | 1 | Ring oscillator output, asynchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| sample_done | output | 1 | One-cycle pulse at each window end |
| freq_err | output | 1 | Sticky out-of-bounds frequency flag |
| seeded | output | 1 | Entropy source judged usable |

## Verification
The bench builds the block with CNT_W=8 and DEF_LEN=16. With these values the reset bounds are 4 and 128, and the edge counter saturates at 255. A 600-clock window driven by a two-clock oscillator period therefore pushes the counter past its ceiling within a short run, and that run fails if the counter wraps. The oscillator toggles on a fixed period, and each window length is a multiple of that period. Every window therefore holds an exact, phase-independent number of edges, which lets the bench place the bounds exactly on, one above, and one below the count. Window lengths of 0, 32, 64 and 600 cover the single-cycle window, the gap between done pulses, and the sticky-error case, where the oscillator is sped up in the middle of a run.

// File: rtl/osc_mon_pkg.sv
package osc_mon_pkg;

  localparam int LEN_W   = 16;  // window length field width
  localparam int LEN_LSB = 16;  // field position inside the seed word

  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_SEED = 2'd1,
    SEL_FMIN = 2'd2,
    SEL_FMAX = 2'd3
  } reg_sel_e;

  // lower bound rule: a quarter of the window length
  function automatic longint unsigned low_limit_of(longint unsigned len);
    return len >> 2;
  endfunction

  // upper bound rule: eight times the window length, clipped to the counter range
  function automatic longint unsigned high_limit_of(longint unsigned len, int cnt_w);
    longint unsigned top;
    longint unsigned hi;
    top = (64'd1 << cnt_w) - 64'd1;
    hi  = len << 3;
    return (hi > top) ? top : hi;
  endfunction

endpackage

// File: rtl/osc_sync_edge.sv
module osc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);

  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~last_q;

endmodule

// File: rtl/osc_cfg_regs.sv
module osc_cfg_regs
  import osc_mon_pkg::*;
#(
  parameter int CNT_W   = 20,
  parameter int DEF_LEN = 1600
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic             prog,
  output logic [LEN_W-1:0] len,
  output logic [CNT_W-1:0] fmin,
  output logic [CNT_W-1:0] fmax
);

  localparam logic [LEN_W-1:0] RST_LEN = LEN_W'(DEF_LEN);
  localparam logic [CNT_W-1:0] RST_MIN =
    CNT_W'(low_limit_of(longint'(DEF_LEN)));
  localparam logic [CNT_W-1:0] RST_MAX =
    CNT_W'(high_limit_of(longint'(DEF_LEN), CNT_W));

  reg_sel_e sel;
  logic     cfg_open;

  assign sel      = reg_sel_e'(addr);
  assign cfg_open = wr_en && prog;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog <= 1'b1;
      len  <= RST_LEN;
      fmin <= RST_MIN;
      fmax <= RST_MAX;
    end else begin
      if (wr_en && sel == SEL_MODE) prog <= wdata[0];
      if (cfg_open) begin
        case (sel)
          SEL_SEED: len  <= wdata[LEN_LSB +: LEN_W];
          SEL_FMIN: fmin <= wdata[CNT_W-1:0];
          SEL_FMAX: fmax <= wdata[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_MODE: rdata[0]                 = prog;
      SEL_SEED: rdata[LEN_LSB +: LEN_W]  = len;
      SEL_FMIN: rdata[CNT_W-1:0]         = fmin;
      SEL_FMAX: rdata[CNT_W-1:0]         = fmax;
      default:  rdata                    = '0;
    endcase
  end

endmodule

// File: rtl/osc_window_ctr.sv
module osc_window_ctr
  import osc_mon_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog,
  input  logic [LEN_W-1:0] len,
  input  logic [CNT_W-1:0] fmin,
  input  logic [CNT_W-1:0] fmax,
  input  logic             rise,
  output logic             win_end,
  output logic [CNT_W-1:0] edge_cnt,
  output logic             sample_done,
  output logic             freq_err,
  output logic             seeded
);

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] sat_bump(logic [CNT_W-1:0] c, logic inc);
    return (c == CNT_TOP) ? CNT_TOP : c + CNT_W'(inc);
  endfunction

  function automatic logic outside_band(logic [CNT_W-1:0] c,
                                        logic [CNT_W-1:0] lo,
                                        logic [CNT_W-1:0] hi);
    return (c < lo) || (c > hi);
  endfunction

  logic [LEN_W-1:0] clk_cnt;
  logic [LEN_W:0]   next_pos;
  logic [CNT_W-1:0] total;
  logic             bad;

  assign next_pos = {1'b0, clk_cnt} + 1'b1;
  assign win_end  = !prog && (next_pos >= {1'b0, len});
  assign total    = sat_bump(edge_cnt, rise);
  assign bad      = outside_band(total, fmin, fmax);

  always_ff @(posedge clk) begin
    if (!rst_n || prog) begin
      clk_cnt     <= '0;
      edge_cnt    <= '0;
      sample_done <= 1'b0;
      freq_err    <= 1'b0;
      seeded      <= 1'b0;
    end else begin
      sample_done <= win_end;
      if (win_end) begin
        clk_cnt  <= '0;
        edge_cnt <= '0;
        freq_err <= freq_err | bad;
        seeded   <= !(freq_err | bad);
      end else begin
        clk_cnt  <= next_pos[LEN_W-1:0];
        edge_cnt <= total;
      end
    end
  end

endmodule

// File: rtl/osc_freq_monitor.sv
module osc_freq_monitor
  import osc_mon_pkg::*;
#(
  parameter int CNT_W   = 20,
  parameter int DEF_LEN = 1600
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        osc_in,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sample_done,
  output logic        freq_err,
  output logic        seeded
);

  logic             cfg_prog;
  logic [LEN_W-1:0] cfg_len;
  logic [CNT_W-1:0] cfg_min;
  logic [CNT_W-1:0] cfg_max;
  logic             osc_rise;
  logic             win_end;
  logic [CNT_W-1:0] edge_cnt;

  osc_sync_edge #(.STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (osc_in),
    .rise     (osc_rise)
  );

  osc_cfg_regs #(.CNT_W(CNT_W), .DEF_LEN(DEF_LEN)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .prog  (cfg_prog),
    .len   (cfg_len),
    .fmin  (cfg_min),
    .fmax  (cfg_max)
  );

  osc_window_ctr #(.CNT_W(CNT_W)) u_win (
    .clk         (clk),
    .rst_n       (rst_n),
    .prog        (cfg_prog),
    .len         (cfg_len),
    .fmin        (cfg_min),
    .fmax        (cfg_max),
    .rise        (osc_rise),
    .win_end     (win_end),
    .edge_cnt    (edge_cnt),
    .sample_done (sample_done),
    .freq_err    (freq_err),
    .seeded      (seeded)
  );

endmodule

// File: rtl/osc_freq_monitor_chk.sv
module osc_freq_monitor_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             prog,
  input logic             sample_done,
  input logic             freq_err,
  input logic             seeded,
  input logic             win_end,
  input logic [CNT_W-1:0] edge_cnt,
  input logic [15:0]      cfg_len,
  input logic [CNT_W-1:0] cfg_min,
  input logic [CNT_W-1:0] cfg_max
);

  assert_cfg_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !prog |=> ($stable(cfg_len) && $stable(cfg_min) && $stable(cfg_max)));

  assert_done_needs_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_done |-> $past(!prog));

  assert_prog_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    prog |=> (!sample_done && !freq_err && !seeded));

  assert_done_after_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> sample_done);

  assert_cnt_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_cnt == {CNT_W{1'b1}} && !win_end && !prog) |=> (edge_cnt == {CNT_W{1'b1}}));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_err && !prog) |=> freq_err);

  assert_no_seed_on_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    freq_err |-> !seeded);

endmodule

bind osc_freq_monitor osc_freq_monitor_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .prog        (cfg_prog),
  .sample_done (sample_done),
  .freq_err    (freq_err),
  .seeded      (seeded),
  .win_end     (win_end),
  .edge_cnt    (edge_cnt),
  .cfg_len     (cfg_len),
  .cfg_min     (cfg_min),
  .cfg_max     (cfg_max)
);

// File: tb/osc_freq_monitor_test.sv
`timescale 1ns/1ps
module osc_freq_monitor_test;

  localparam int CNT_W   = 8;
  localparam int DEF_LEN = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_in = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        sample_done;
  logic        freq_err;
  logic        seeded;

  osc_freq_monitor #(.CNT_W(CNT_W), .DEF_LEN(DEF_LEN)) uut (
    .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sample_done(sample_done), .freq_err(freq_err), .seeded(seeded)
  );

  always #2.5 clk = ~clk;  // 200 MHz

  typedef struct {
    bit    err;
    bit    sd;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   errs = 0;
  int   checks = 0;
  int   cyc = 0;
  int   half = 0;      // oscillator half period in clocks, 0 = hold
  bit   strict = 1'b1; // unexpected sample_done is a failure
  int   run_seq = 0;
  int   last_seq = -1;
  int   last_cyc = 0;
  int   exp_gap = 1;

  task automatic chk(bit ok, string tag, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  always @(posedge clk) cyc++;

  // oscillator model: toggles away from the sampling edge
  initial begin
    forever begin
      if (half == 0) @(negedge clk);
      else begin
        repeat (half) @(negedge clk);
        osc_in = ~osc_in;
      end
    end
  end

  // monitor: pops one expectation per window end
  always @(negedge clk) begin : monitor
    exp_t e;
    if (rst_n && sample_done) begin
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        chk(freq_err == e.err, e.tag, "freq_err at window end", freq_err, e.err);
        chk(seeded == e.sd, "R10", "seeded at window end", seeded, e.sd);
        if (run_seq == last_seq)
          chk(cyc - last_cyc == exp_gap, "R5", "cycles between sample_done",
              cyc - last_cyc, exp_gap);
        last_seq = run_seq;
        last_cyc = cyc;
      end else if (strict) begin
        chk(1'b0, "R4", "sample_done with nothing expected", 1, 0);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] expv, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata == expv, tag, $sformatf("readback addr %0d", a), reg_rdata, expv);
  endtask

  task automatic enter_prog();
    strict = 1'b0;
    wr(2'd0, 32'd1);
    repeat (2) @(negedge clk);
    strict = 1'b1;
  endtask

  task automatic cfg(input int len, input int lo, input int hi, input int h);
    enter_prog();
    wr(2'd1, 32'(len) << 16);
    wr(2'd2, 32'(lo));
    wr(2'd3, 32'(hi));
    half = h;
    repeat (40) @(negedge clk);
  endtask

  task automatic push(input int n, input bit err, input bit sd, input string tag);
    exp_t e;
    e.err = err; e.sd = sd; e.tag = tag;
    for (int i = 0; i < n; i++) exp_q.push_back(e);
  endtask

  task automatic go(input int gap);
    exp_gap = gap;
    run_seq++;
    wr(2'd0, 32'd0);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R2: reset values through the register port
    chk(sample_done == 0 && freq_err == 0 && seeded == 0, "R1", "flags after reset",
        {sample_done, freq_err, seeded}, 0);
    rd_chk(2'd0, 32'd1, "R1");
    rd_chk(2'd1, 32'(DEF_LEN) << 16, "R2");
    rd_chk(2'd2, 32'(DEF_LEN / 4), "R1");
    rd_chk(2'd3, 32'(DEF_LEN * 8), "R1");

    // R6 / R7: count 64/4 = 16 sits exactly on both bounds
    cfg(64, 16, 16, 2);
    push(3, 1'b0, 1'b1, "R7");
    go(64);
    drain();

    // R6: upper bound one below the count
    cfg(64, 0, 15, 2);
    chk(freq_err == 0 && seeded == 0, "R4", "flags cleared in program mode",
        {freq_err, seeded}, 0);
    push(2, 1'b1, 1'b0, "R6");
    go(64);
    drain();

    // R7: lower bound one above the count; R4 silence in program mode
    cfg(64, 17, 255, 2);
    chk(freq_err == 0 && seeded == 0, "R4", "flags cleared by program bit",
        {freq_err, seeded}, 0);
    repeat (100) @(negedge clk);
    push(2, 1'b1, 1'b0, "R7");
    go(64);
    drain();

    // R9: too slow at first, then in band, error must stay
    cfg(64, 8, 32, 8);
    push(4, 1'b1, 1'b0, "R9");
    go(64);
    while (exp_q.size() > 3) @(negedge clk);
    half = 4;
    drain();
    enter_prog();
    chk(freq_err == 0, "R9", "error cleared by program bit", freq_err, 0);

    // R3: configuration writes during run mode are dropped
    cfg(32, 8, 8, 2);
    push(3, 1'b0, 1'b1, "R3");
    go(32);
    wr(2'd3, 32'd0);
    wr(2'd2, 32'd200);
    wr(2'd1, 32'd5 << 16);
    rd_chk(2'd1, 32'd32 << 16, "R3");
    rd_chk(2'd2, 32'd8, "R3");
    rd_chk(2'd3, 32'd8, "R3");
    rd_chk(2'd0, 32'd0, "R3");
    drain();

    // R8: 300 edges in the window saturate at 255, within 200..255
    cfg(600, 200, 255, 1);
    push(2, 1'b0, 1'b1, "R8");
    go(600);
    drain();

    // R5: length 0 acts as a one-cycle window
    cfg(0, 0, 1, 3);
    rd_chk(2'd1, 32'd0, "R5");
    push(6, 1'b0, 1'b1, "R5");
    go(1);
    drain();
    enter_prog();
    chk(seeded == 0, "R4", "seeded cleared by program bit", seeded, 0);

    finish_up();
  end

endmodule